// File: doc/BRIEF.md
# Scanned Keypad Encoder

This block reads a 4x4 matrix of push buttons. It enables one row line at a time from a one-hot ring and listens on the four column lines. The columns are pulled high when idle, so a closed switch on the enabled row pulls one of them low. A press stops the ring on that row. The block then reports the key as a 4-bit code, using the row position and the column position, and raises a single-cycle valid strobe. When every column is high again, the press is treated as released and the ring carries on from the row where it stopped.

The columns first go through a short synchronizer. The ring stays on each row for a fixed dwell of clock cycles, and column data is only trusted once the synchronizer has caught up with the row that is currently driven. Row lines are given as an active-low level plus a per-row output enable, so a pad driver can release every row except the active one.

The key result is a valid-only stream with no ready input, so the consumer cannot apply back-pressure. It must capture `key_code` in the cycle that `key_valid` is high. After that cycle the code stays readable until the next press.

Top module: `kpd_scan_encoder`

## Requirements
- R1: While reset is held and in the cycle after it, row 0 is the enabled row (`row_oe` = 4'b0001, `row_drv_n` = 4'b1110), `key_valid` is 0 and `key_code` is 0.
- R2: Exactly one bit of `row_oe` is set at every cycle, and `row_drv_n` is its bitwise inverse. Row index i corresponds to bit i.
- R3: With no key closed, the enabled row moves from bit i to bit i+1 (wrapping 3 to 0) every DWELL (default 8) cycles.
- R4: The column inputs pass through SYNC_STAGES (default 2) flops, so a press raises `key_valid` no sooner than SYNC_STAGES+1 cycles after the column falls.
- R5: Once a press is detected, the enabled row stays fixed for as long as any column is low.
- R6: Each press gives exactly one `key_valid` pulse, one cycle wide. `key_code` = {row index in bits 3:2, column index in bits 1:0}.
- R7: If several columns are low on the frozen row, the lowest column index is encoded.
- R8: `key_code` does not change except in a cycle where `key_valid` is high, and it keeps the last key after release.
- R9: After release, the same row stays enabled until exactly DWELL+SYNC_STAGES+1 cycles after the columns return high, then the ring moves to the next row.
- R10: A key held on any row produces `key_valid` within ROWS*DWELL+SYNC_STAGES+3 cycles of being pressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_n | input | 4 | Column sense lines, low means a closed switch on the enabled row |
| row_drv_n | output | 4 | Row drive level, low on the enabled row |
| row_oe | output | 4 | Row output enable, one-hot; rows that are not enabled float |
| key_valid | output | 1 | One-cycle strobe marking a new key code |
| key_code | output | 4 | {row index, column index} of the last pressed key |

## Verification
A column edge takes SYNC_STAGES+1 cycles to turn into `key_valid` when the row has already settled. A release takes SYNC_STAGES+1 cycles to free the ring, plus DWELL cycles before the row moves. The bench samples only at falling edges and timestamps every press in a scoreboard queue. The monitor that pops the queue compares the measured latency against the lower bound (R4) and the upper bound (R10). The release check counts falling edges until the row changes and expects exactly DWELL+SYNC_STAGES+1.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  // Index of the lowest set bit of a vector (0 if none is set).
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-2:0], din[b]};
    end
    assign dout[b] = sh[STAGES-1];
  end

endmodule

// File: rtl/kpd_ring.sv
module kpd_ring #(
  parameter int ROWS   = 4,
  parameter int DWELL  = 8,
  parameter int SETTLE = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            restart,
  output logic [ROWS-1:0] row_oe,
  output logic            settled
);

  localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DWELL - 1);
  localparam logic [CNT_W-1:0] SETL  = CNT_W'(SETTLE);

  logic [CNT_W-1:0] cnt;
  logic [ROWS-1:0]  ring;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      ring <= ROWS'(1);
    end else if (restart) begin
      cnt <= '0;
    end else if (!hold) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        ring <= {ring[ROWS-2:0], ring[ROWS-1]};
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign row_oe  = ring;
  assign settled = (cnt >= SETL);

endmodule

// File: rtl/kpd_detect.sv
module kpd_detect
  import kpd_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [COLS-1:0]                        col_s,
  input  logic                                   settled,
  input  logic [ROWS-1:0]                        row_oe,
  output logic                                   hit,
  output logic                                   frozen,
  output logic                                   release_now,
  output logic                                   key_valid,
  output logic [$clog2(ROWS)+$clog2(COLS)-1:0]   key_code
);

  localparam int RIDX_W = $clog2(ROWS);
  localparam int CIDX_W = $clog2(COLS);

  logic              col_nand;
  logic [RIDX_W-1:0] ridx;
  logic [CIDX_W-1:0] cidx;

  assign col_nand    = ~&col_s;
  assign hit         = settled && !frozen && col_nand;
  assign release_now = frozen && !col_nand;
  assign ridx        = RIDX_W'(lowest_set(32'(row_oe)));
  assign cidx        = CIDX_W'(lowest_set(32'(~col_s)));

  always_ff @(posedge clk) begin
    if (rst) begin
      frozen    <= 1'b0;
      key_valid <= 1'b0;
      key_code  <= '0;
    end else begin
      key_valid <= hit;
      if (hit) begin
        frozen   <= 1'b1;
        key_code <= {ridx, cidx};
      end else if (release_now) begin
        frozen <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/kpd_scan_encoder.sv
module kpd_scan_encoder #(
  parameter int ROWS        = 4,
  parameter int COLS        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DWELL       = 8,
  localparam int CODE_W     = $clog2(ROWS) + $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COLS-1:0]   col_n,
  output logic [ROWS-1:0]   row_drv_n,
  output logic [ROWS-1:0]   row_oe,
  output logic              key_valid,
  output logic [CODE_W-1:0] key_code
);

  logic [COLS-1:0] col_s;
  logic            settled;
  logic            hit;
  logic            frozen;
  logic            release_now;
  logic            scan_hold;

  kpd_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (col_n),
    .dout (col_s)
  );

  assign scan_hold = frozen | hit;

  kpd_ring #(.ROWS(ROWS), .DWELL(DWELL), .SETTLE(SYNC_STAGES)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .hold    (scan_hold),
    .restart (release_now),
    .row_oe  (row_oe),
    .settled (settled)
  );

  kpd_detect #(.ROWS(ROWS), .COLS(COLS)) u_det (
    .clk         (clk),
    .rst         (rst),
    .col_s       (col_s),
    .settled     (settled),
    .row_oe      (row_oe),
    .hit         (hit),
    .frozen      (frozen),
    .release_now (release_now),
    .key_valid   (key_valid),
    .key_code    (key_code)
  );

  assign row_drv_n = ~row_oe;

endmodule

// File: rtl/kpd_scan_encoder_chk.sv
module kpd_scan_encoder_chk #(
  parameter int ROWS   = 4,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ROWS-1:0]   row_oe,
  input logic [ROWS-1:0]   row_drv_n,
  input logic              key_valid,
  input logic [CODE_W-1:0] key_code
);

  logic [ROWS-1:0] prev_oe;
  always_ff @(posedge clk) prev_oe <= row_oe;

  assert_one_row_R2: assert property (@(posedge clk) disable iff (rst)
    ($countones(row_oe) == 1) && (row_drv_n == ~row_oe));

  assert_rotate_R3: assert property (@(posedge clk) disable iff (rst)
    (row_oe != prev_oe) |-> (row_oe == {prev_oe[ROWS-2:0], prev_oe[ROWS-1]}));

  assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> $stable(row_oe));

  assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  assert_hold_code_R8: assert property (@(posedge clk) disable iff (rst)
    !key_valid |-> $stable(key_code));

endmodule

bind kpd_scan_encoder kpd_scan_encoder_chk #(.ROWS(ROWS), .CODE_W(CODE_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .row_oe    (row_oe),
  .row_drv_n (row_drv_n),
  .key_valid (key_valid),
  .key_code  (key_code)
);

// File: tb/kpd_scan_encoder_tb_top.sv
`timescale 1ns/1ps
module kpd_scan_encoder_tb_top;

  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int SYNC  = 2;
  localparam int DWELL = 8;
  localparam int BOUND = ROWS*DWELL + SYNC + 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [COLS-1:0] col_n;
  logic [ROWS-1:0] row_drv_n;
  logic [ROWS-1:0] row_oe;
  logic            key_valid;
  logic [3:0]      key_code;
  logic [15:0]     keys = '0;

  always #2.5 clk = ~clk;

  kpd_scan_encoder #(.ROWS(ROWS), .COLS(COLS), .SYNC_STAGES(SYNC), .DWELL(DWELL)) dut_i (
    .clk(clk), .rst(rst), .col_n(col_n), .row_drv_n(row_drv_n),
    .row_oe(row_oe), .key_valid(key_valid), .key_code(key_code)
  );

  // Keypad model: a closed switch ties its column to its row when that row is driven.
  always_comb begin
    col_n = '1;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (keys[r*COLS+c] && row_oe[r]) col_n[c] = 1'b0;
  end

  int nchk = 0, nfail = 0, cyc = 0, valid_seen = 0;
  bit prev_valid = 1'b0;

  typedef struct { logic [3:0] code; int t; } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard whenever a code is presented.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if ((row_oe != 0) && (($countones(row_oe) != 1) || (row_drv_n != ~row_oe)))
        chk(1'b0, "R2", row_drv_n, ~row_oe);
      if (key_valid) begin
        valid_seen++;
        chk(!prev_valid, "R6 pulse width", 2, 1);
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected valid", key_code, -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(key_code == e.code, "R6 code", key_code, e.code);
          chk((cyc - e.t) >= SYNC + 1, "R4 latency min", cyc - e.t, SYNC + 1);
          chk((cyc - e.t) <= BOUND, "R10 latency max", cyc - e.t, BOUND);
        end
      end
      prev_valid = key_valid;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // Driver: closes keys on one row, checks freeze, release and resume.
  task automatic press(input int r, input logic [3:0] cmask, input int exp_c);
    int n;
    int waited;
    bit stable;
    logic [ROWS-1:0] fr;
    exp_t e;
    logic [3:0] code;
    code = 4'(r*4 + exp_c);
    @(negedge clk);
    e.code = code; e.t = cyc;
    exp_q.push_back(e);
    for (int c = 0; c < COLS; c++) keys[r*COLS+c] = cmask[c];
    n = valid_seen;
    waited = 0;
    while (valid_seen == n && waited < BOUND + 5) begin tick(); waited++; end
    chk(valid_seen == n + 1, "R10 valid arrived", valid_seen - n, 1);
    chk(row_oe == ROWS'(1 << r), "R5 frozen row", row_oe, 1 << r);
    fr = row_oe;
    stable = 1'b1;
    for (int i = 0; i < 3*DWELL; i++) begin
      tick();
      if (row_oe != fr || key_valid) stable = 1'b0;
    end
    chk(stable, "R5 row held while pressed", stable, 1);
    chk(key_code == code, "R8 code held", key_code, code);
    @(negedge clk);
    keys = '0;
    waited = 0;
    while (row_oe == fr && waited < DWELL + SYNC + 10) begin tick(); waited++; end
    chk(waited == DWELL + SYNC + 1, "R9 resume delay", waited, DWELL + SYNC + 1);
    chk(row_oe == {fr[ROWS-2:0], fr[ROWS-1]}, "R9 next row", row_oe, {fr[ROWS-2:0], fr[ROWS-1]});
    chk(key_code == code, "R8 code kept after release", key_code, code);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int gap;
    logic [ROWS-1:0] last;
    repeat (3) @(negedge clk);
    chk(row_oe == 4'b0001, "R1 row_oe in reset", row_oe, 1);
    chk(row_drv_n == 4'b1110, "R1 row_drv_n in reset", row_drv_n, 14);
    chk(key_valid == 1'b0, "R1 valid in reset", key_valid, 0);
    chk(key_code == 4'd0, "R1 code in reset", key_code, 0);
    rst = 1'b0;
    tick();
    chk(row_oe == 4'b0001 && key_valid == 1'b0, "R1 after reset", row_oe, 1);

    // R3: idle scanning cadence and order
    last = row_oe;
    while (row_oe == last) tick();
    for (int k = 0; k < 5; k++) begin
      last = row_oe;
      gap = 0;
      while (row_oe == last && gap < 4*DWELL) begin tick(); gap++; end
      chk(gap == DWELL, "R3 dwell", gap, DWELL);
      chk(row_oe == {last[ROWS-2:0], last[ROWS-1]}, "R3 order", row_oe, {last[ROWS-2:0], last[ROWS-1]});
    end

    press(0, 4'b0001, 0);
    press(3, 4'b1000, 3);
    press(2, 4'b0100, 2);
    press(1, 4'b0010, 1);
    press(3, 4'b0001, 0);
    // R7: several columns on one row, lowest wins
    press(1, 4'b1010, 1);
    press(2, 4'b1101, 0);
    press(0, 4'b1100, 2);

    repeat (5) tick();
    chk(exp_q.size() == 0, "R6 all codes delivered", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule